// File: doc/BRIEF.md
# Character Display Sequencer with Decimal Result Output

This block drives a two-row, sixteen-column character display over an 8-bit parallel write bus with a register-select line, a read/write line held at write, and an enable strobe. After reset it runs a fixed, timed power-on command script. It then echoes keypad characters as they arrive. An equals key moves the cursor to the second row, and the first key after that clears the screen before it is shown. A completed 32-bit arithmetic result is turned into decimal digits by a serial shift-and-add-3 converter and written out one digit at a time.

The display's busy flag is never read. Every write is paced by counted clock cycles: a fixed enable-high time, then an enable-low interval chosen by the kind of write. All interval lengths are parameters in clock cycles, so a testbench can shorten them. Each event is a one-cycle pulse. An event is taken only while the sequencer is idle, and events that arrive while it is busy are dropped.

Top module: `lcd_seq_ctrl`

## Requirements
- R1: While reset is held, the enable line is low and read/write is low. The first write after reset is command 38h.
- R2: The power-on script is nine command writes (register select 0): 38h four times, then 08h, 01h, 06h, 0Fh and 02h, in that order.
- R3: The enable-low interval after each 38h write is at least INIT_LONG cycles. After each of the other five script writes it is at least INIT_SHORT cycles.
- R4: Every write holds enable high for exactly E_HI cycles. Data and register select stay unchanged while enable is high.
- R5: A key_valid pulse with a character other than 3Dh writes that character as data (register select 1).
- R6: A key of 3Dh ('=') writes 3Dh as data, then command C0h (start of row 2).
- R7: The first key after an R6 row switch is preceded by command 01h (clear). Later keys are written without a clear.
- R8: A res_valid pulse writes the decimal value of res_value, most significant digit first, with each digit as data 30h+digit and no leading zeros.
- R9: A result of zero writes the single character 30h.
- R10: Before every write after the script, enable stays low for at least DIGIT_GAP cycles. After a clear command it stays low for at least INIT_SHORT cycles.
- R11: The read/write line is low at all times.
- R12: If key_valid and res_valid arrive in the same idle cycle, only the key is written and the result is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| key_valid | input | 1 | One-cycle pulse: a key character is present |
| key_char | input | 8 | Character code of the key |
| res_valid | input | 1 | One-cycle pulse: a result is present |
| res_value | input | 32 | Unsigned binary result |
| lcd_db | output | 8 | Display data bus |
| lcd_rs | output | 1 | Register select: 0 command, 1 data |
| lcd_rw | output | 1 | Read/write, always write (0) |
| lcd_e | output | 1 | Enable strobe |

## Verification
Each write drives enable high on the second clock edge after the sequencer picks it, and holds it for exactly E_HI cycles. The next write cannot start until its gap has elapsed plus one more cycle. The first digit of a result appears about RES_W+3 cycles after res_valid, because the serial converter must run first. The bench therefore does not wait for fixed delays. A bus monitor that samples on the falling clock edge records every rising and falling enable edge with its cycle number, data and select. After each stimulus the bench waits for a quiet window longer than any gap and then compares the recorded writes and their measured high and low widths with values it computes itself.

// File: rtl/lcd_pkg.sv
package lcd_pkg;

  typedef enum logic [2:0] {
    ST_INIT, ST_IDLE, ST_CLR, ST_CHAR, ST_ROW2, ST_CONV, ST_DIG
  } seq_st_t;

  typedef enum logic [1:0] {PH_IDLE, PH_HI, PH_LO} wr_ph_t;

  localparam logic [7:0] CMD_CLEAR = 8'h01;
  localparam logic [7:0] CMD_ROW2  = 8'hC0;
  localparam logic [7:0] CHR_EQ    = 8'h3D;
  localparam logic [3:0] INIT_LAST = 4'd8;
  localparam logic [3:0] INIT_NFUNC = 4'd4;

  // Power-on command script, indexed by step
  function automatic logic [7:0] init_code(input logic [3:0] step);
    case (step)
      4'd0, 4'd1, 4'd2, 4'd3: init_code = 8'h38;
      4'd4:    init_code = 8'h08;
      4'd5:    init_code = 8'h01;
      4'd6:    init_code = 8'h06;
      4'd7:    init_code = 8'h0F;
      default: init_code = 8'h02;
    endcase
  endfunction

endpackage

// File: rtl/lcd_wr_timer.sv
module lcd_wr_timer
  import lcd_pkg::*;
#(
  parameter int CNT_W = 17,
  parameter int E_HI  = 55
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [7:0]       data_i,
  input  logic             rs_i,
  input  logic [CNT_W-1:0] gap_i,
  output logic [7:0]       db_o,
  output logic             rs_o,
  output logic             e_o,
  output logic             done_o
);

  wr_ph_t           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, gap_q, gap_d;
  logic [7:0]       db_q, db_d;
  logic             rs_q, rs_d;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    gap_d = gap_q;
    db_d  = db_q;
    rs_d  = rs_q;
    case (ph_q)
      PH_IDLE: if (start_i) begin
        ph_d  = PH_HI;
        cnt_d = CNT_W'(E_HI - 1);
        gap_d = gap_i;
        db_d  = data_i;
        rs_d  = rs_i;
      end
      PH_HI: if (cnt_q == '0) begin
        ph_d  = PH_LO;
        cnt_d = gap_q - 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
      PH_LO: if (cnt_q == '0) ph_d = PH_IDLE;
             else             cnt_d = cnt_q - 1'b1;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      gap_q <= '0;
      db_q  <= '0;
      rs_q  <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      gap_q <= gap_d;
      db_q  <= db_d;
      rs_q  <= rs_d;
    end
  end

  assign db_o   = db_q;
  assign rs_o   = rs_q;
  assign e_o    = (ph_q == PH_HI);
  assign done_o = (ph_q == PH_LO) && (cnt_q == '0);

endmodule

// File: rtl/lcd_bcd_conv.sv
module lcd_bcd_conv #(
  parameter int BIN_W  = 32,
  parameter int DIGITS = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [BIN_W-1:0]    bin_i,
  output logic                done_o,
  output logic [4*DIGITS-1:0] bcd_o
);

  localparam int CW = $clog2(BIN_W + 1);
  localparam int BW = 4 * DIGITS;

  logic             run_q, run_d, done_q, done_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [BIN_W-1:0] bin_q, bin_d;
  logic [BW-1:0]    bcd_q, bcd_d, adj;

  // Each decimal column gets +3 when it holds 5 or more, ahead of the shift
  for (genvar g = 0; g < DIGITS; g++) begin : g_adj
    assign adj[g*4 +: 4] = (bcd_q[g*4 +: 4] >= 4'd5) ? bcd_q[g*4 +: 4] + 4'd3
                                                     : bcd_q[g*4 +: 4];
  end

  always_comb begin
    run_d  = run_q;
    cnt_d  = cnt_q;
    bin_d  = bin_q;
    bcd_d  = bcd_q;
    done_d = 1'b0;
    if (start_i) begin
      run_d = 1'b1;
      cnt_d = '0;
      bin_d = bin_i;
      bcd_d = '0;
    end else if (run_q) begin
      bcd_d = {adj[BW-2:0], bin_q[BIN_W-1]};
      bin_d = bin_q << 1;
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CW'(BIN_W - 1)) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      bin_q  <= '0;
      bcd_q  <= '0;
    end else begin
      run_q  <= run_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
      bin_q  <= bin_d;
      bcd_q  <= bcd_d;
    end
  end

  assign done_o = done_q;
  assign bcd_o  = bcd_q;

endmodule

// File: rtl/lcd_seq_ctrl.sv
module lcd_seq_ctrl
  import lcd_pkg::*;
#(
  parameter int E_HI       = 55,
  parameter int INIT_LONG  = 111213,
  parameter int INIT_SHORT = 44485,
  parameter int DIGIT_GAP  = 5425,
  parameter int RES_W      = 32,
  parameter int DIGITS     = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_valid,
  input  logic [7:0]       key_char,
  input  logic             res_valid,
  input  logic [RES_W-1:0] res_value,
  output logic [7:0]       lcd_db,
  output logic             lcd_rs,
  output logic             lcd_rw,
  output logic             lcd_e
);

  localparam int MAX_A = (INIT_LONG > INIT_SHORT) ? INIT_LONG : INIT_SHORT;
  localparam int MAX_B = (DIGIT_GAP > E_HI) ? DIGIT_GAP : E_HI;
  localparam int CNT_W = $clog2(((MAX_A > MAX_B) ? MAX_A : MAX_B) + 1);
  localparam int MIN_A = (INIT_LONG < INIT_SHORT) ? INIT_LONG : INIT_SHORT;
  localparam int MIN_GAP = (MIN_A < DIGIT_GAP) ? MIN_A : DIGIT_GAP;
  localparam int DW = $clog2(DIGITS);
  localparam logic [CNT_W-1:0] G_LONG  = CNT_W'(INIT_LONG);
  localparam logic [CNT_W-1:0] G_SHORT = CNT_W'(INIT_SHORT);
  localparam logic [CNT_W-1:0] G_DIG   = CNT_W'(DIGIT_GAP);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  seq_st_t          st_q, st_d;
  logic [3:0]       step_q, step_d;
  logic             wait_q, wait_d, eq_q, eq_d;
  logic [7:0]       key_q, key_d;
  logic [DW-1:0]    dig_q, dig_d, lead;
  logic             wr_start, wr_done, conv_start, conv_done, wr_rs;
  logic [7:0]       wr_data;
  logic [CNT_W-1:0] wr_gap;
  logic [4*DIGITS-1:0] bcd;
  logic [3:0]       nib;

  lcd_bcd_conv #(.BIN_W(RES_W), .DIGITS(DIGITS)) u_conv (
    .clk(clk), .rst_n(rst_sync_n), .start_i(conv_start), .bin_i(res_value),
    .done_o(conv_done), .bcd_o(bcd));

  lcd_wr_timer #(.CNT_W(CNT_W), .E_HI(E_HI)) u_wr (
    .clk(clk), .rst_n(rst_sync_n), .start_i(wr_start), .data_i(wr_data),
    .rs_i(wr_rs), .gap_i(wr_gap), .db_o(lcd_db), .rs_o(lcd_rs),
    .e_o(lcd_e), .done_o(wr_done));

  // Highest non-zero decimal column; column 0 when the value is zero
  always_comb begin
    lead = '0;
    for (int i = 1; i < DIGITS; i++)
      if (bcd[i*4 +: 4] != 4'd0) lead = DW'(i);
  end
  assign nib = bcd[{dig_q, 2'b00} +: 4];

  // Bus word for the write the current state asks for
  always_comb begin
    wr_data = 8'h00;
    wr_rs   = 1'b0;
    wr_gap  = G_DIG;
    case (st_q)
      ST_INIT: begin
        wr_data = init_code(step_q);
        wr_gap  = (step_q < INIT_NFUNC) ? G_LONG : G_SHORT;
      end
      ST_CLR:  begin wr_data = CMD_CLEAR; wr_gap = G_SHORT; end
      ST_CHAR: begin wr_data = key_q; wr_rs = 1'b1; end
      ST_ROW2: wr_data = CMD_ROW2;
      ST_DIG:  begin wr_data = {4'h3, nib}; wr_rs = 1'b1; end
      default: ;
    endcase
  end

  assign wr_start = !wait_q && (st_q == ST_INIT || st_q == ST_CLR ||
                    st_q == ST_CHAR || st_q == ST_ROW2 || st_q == ST_DIG);

  always_comb begin
    st_d       = st_q;
    step_d     = step_q;
    wait_d     = wait_q;
    eq_d       = eq_q;
    key_d      = key_q;
    dig_d      = dig_q;
    conv_start = 1'b0;
    if (wr_start) wait_d = 1'b1;
    if (wait_q && wr_done) wait_d = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (key_valid) begin
          key_d = key_char;
          st_d  = eq_q ? ST_CLR : ST_CHAR;
        end else if (res_valid) begin
          conv_start = 1'b1;
          st_d       = ST_CONV;
        end
      end
      ST_INIT: if (wait_q && wr_done) begin
        if (step_q == INIT_LAST) st_d = ST_IDLE;
        else                     step_d = step_q + 1'b1;
      end
      ST_CLR: if (wait_q && wr_done) begin
        eq_d = 1'b0;
        st_d = ST_CHAR;
      end
      ST_CHAR: if (wait_q && wr_done)
        st_d = (key_q == CHR_EQ) ? ST_ROW2 : ST_IDLE;
      ST_ROW2: if (wait_q && wr_done) begin
        eq_d = 1'b1;
        st_d = ST_IDLE;
      end
      ST_CONV: if (conv_done) begin
        dig_d = lead;
        st_d  = ST_DIG;
      end
      ST_DIG: if (wait_q && wr_done) begin
        if (dig_q == '0) st_d = ST_IDLE;
        else             dig_d = dig_q - 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q   <= ST_INIT;
      step_q <= '0;
      wait_q <= 1'b0;
      eq_q   <= 1'b0;
      key_q  <= '0;
      dig_q  <= '0;
    end else begin
      st_q   <= st_d;
      step_q <= step_d;
      wait_q <= wait_d;
      eq_q   <= eq_d;
      key_q  <= key_d;
      dig_q  <= dig_d;
    end
  end

  assign lcd_rw = 1'b0;

endmodule

// File: rtl/lcd_seq_chk.sv
module lcd_seq_chk #(
  parameter int E_HI    = 55,
  parameter int MIN_GAP = 5425
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] lcd_db,
  input logic       lcd_rs,
  input logic       lcd_rw,
  input logic       lcd_e
);

  logic [31:0] hi_cnt, lo_cnt;
  logic        fell_once;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt    <= '0;
      lo_cnt    <= '0;
      fell_once <= 1'b0;
    end else begin
      hi_cnt <= lcd_e ? hi_cnt + 1 : '0;
      lo_cnt <= lcd_e ? '0 : lo_cnt + 1;
      if (!lcd_e && hi_cnt != '0) fell_once <= 1'b1;
    end
  end

  // R11: never a read cycle
  p_rw_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_rw == 1'b0);

  // R4: strobe width is exact
  p_e_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!lcd_e && hi_cnt != '0) |-> hi_cnt == 32'(E_HI));

  // R4: bus word held while strobe is high
  p_bus_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_e && hi_cnt != '0) |-> ($stable(lcd_db) && $stable(lcd_rs)));

  // R3 / R10: no write starts before the shortest gap has passed
  p_gap_min_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_e && hi_cnt == '0 && fell_once) |-> lo_cnt >= 32'(MIN_GAP));

  // R1: strobe low while in reset and for the first cycle out of it
  p_e_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !lcd_e);

endmodule

bind lcd_seq_ctrl lcd_seq_chk #(.E_HI(E_HI), .MIN_GAP(MIN_GAP)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .lcd_db(lcd_db), .lcd_rs(lcd_rs),
  .lcd_rw(lcd_rw), .lcd_e(lcd_e));

// File: tb/tb_lcd_seq_ctrl.sv
`timescale 1ns/1ps
module tb_lcd_seq_ctrl;

  localparam int E_HI = 3, LONG = 40, SHORT = 20, DGAP = 8;
  localparam int NW = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        key_valid = 1'b0, res_valid = 1'b0;
  logic [7:0]  key_char = '0;
  logic [31:0] res_value = '0;
  logic [7:0]  lcd_db;
  logic        lcd_rs, lcd_rw, lcd_e;

  always #2.5 clk = ~clk;

  lcd_seq_ctrl #(.E_HI(E_HI), .INIT_LONG(LONG), .INIT_SHORT(SHORT),
                 .DIGIT_GAP(DGAP)) dut (
    .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_char(key_char),
    .res_valid(res_valid), .res_value(res_value), .lcd_db(lcd_db),
    .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_e(lcd_e));

  int checks = 0, errors = 0, nw = 0, cyc = 0, rw_bad = 0;
  bit finished = 0;
  logic [7:0] w_db [NW];
  logic       w_rs [NW];
  int         w_rise [NW], w_fall [NW], w_hi [NW], w_lo [NW];
  logic       e_prev = 1'b0;

  // Bus monitor, sampled on the falling clock edge
  always @(negedge clk) begin
    cyc++;
    if (lcd_rw !== 1'b0) rw_bad++;
    if (lcd_e && !e_prev && nw < NW) begin
      w_db[nw] = lcd_db; w_rs[nw] = lcd_rs; w_rise[nw] = cyc;
      w_lo[nw] = (nw > 0) ? cyc - w_fall[nw-1] : 0;
      nw++;
    end
    if (!lcd_e && e_prev && nw > 0) begin
      w_fall[nw-1] = cyc;
      w_hi[nw-1] = cyc - w_rise[nw-1];
    end
    e_prev = lcd_e;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic settle();
    int idle = 0;
    while (idle < 80) begin
      @(negedge clk);
      if (lcd_e) idle = 0; else idle++;
    end
  endtask

  task automatic press(input logic [7:0] c);
    @(negedge clk); key_valid = 1'b1; key_char = c;
    @(negedge clk); key_valid = 1'b0;
    settle();
  endtask

  task automatic result(input logic [31:0] v);
    @(negedge clk); res_valid = 1'b1; res_value = v;
    @(negedge clk); res_valid = 1'b0;
    settle();
  endtask

  task automatic expect_w(input int idx, input logic rs, input logic [7:0] d,
                          input string req);
    check(idx < nw && w_rs[idx] == rs && w_db[idx] == d, req, "write",
          (idx < nw) ? {w_rs[idx], w_db[idx]} : 'hfff, {rs, d});
  endtask

  function automatic string dec_str(input logic [31:0] v);
    return $sformatf("%0d", v);
  endfunction

  task automatic check_result(input logic [31:0] v, input string req);
    int    m = nw;
    string s = dec_str(v);
    bit    ok;
    result(v);
    ok = (nw - m == s.len());
    for (int i = 0; i < s.len() && ok; i++)
      if (w_rs[m+i] !== 1'b1 || w_db[m+i] !== s[i]) ok = 0;
    check(ok, req, $sformatf("digits of %0d", v), nw - m, s.len());
  endtask

  initial begin
    int m;
    bit ok;
    string keys = "0123456789+-*/C";
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    check(lcd_e == 1'b0 && lcd_rw == 1'b0, "R1", "e/rw in reset",
          {lcd_e, lcd_rw}, 0);
    rst_n = 1'b1;
    settle();

    // R1/R2: power-on script
    check(nw == 9, "R2", "script length", nw, 9);
    expect_w(0, 1'b0, 8'h38, "R1");
    for (int i = 1; i < 4; i++) expect_w(i, 1'b0, 8'h38, "R2");
    expect_w(4, 1'b0, 8'h08, "R2");
    expect_w(5, 1'b0, 8'h01, "R2");
    expect_w(6, 1'b0, 8'h06, "R2");
    expect_w(7, 1'b0, 8'h0F, "R2");
    expect_w(8, 1'b0, 8'h02, "R2");
    // R3: gaps in the script
    for (int i = 1; i < 9 && i < nw; i++)
      check(w_lo[i] >= ((i <= 4) ? LONG : SHORT), "R3", "script gap",
            w_lo[i], (i <= 4) ? LONG : SHORT);

    // R5: plain key
    m = nw; press("7");
    check(nw - m == 1, "R5", "key write count", nw - m, 1);
    expect_w(m, 1'b1, "7", "R5");

    // R6: equals then row switch
    m = nw; press(8'h3D);
    check(nw - m == 2, "R6", "equals write count", nw - m, 2);
    expect_w(m, 1'b1, 8'h3D, "R6");
    expect_w(m+1, 1'b0, 8'hC0, "R6");

    // R7: restart on first key after equals, with long gap (R10)
    m = nw; press("4");
    check(nw - m == 2, "R7", "restart write count", nw - m, 2);
    expect_w(m, 1'b0, 8'h01, "R7");
    expect_w(m+1, 1'b1, "4", "R7");
    if (m + 1 < nw) check(w_lo[m+1] >= SHORT, "R10", "gap after clear",
                          w_lo[m+1], SHORT);
    m = nw; press("5");
    check(nw - m == 1, "R7", "no second clear", nw - m, 1);
    expect_w(m, 1'b1, "5", "R7");

    // R9 / R8 directed corners
    check_result(32'd0, "R9");
    check_result(32'hFFFF_FFFF, "R8");
    check_result(32'd1000000000, "R8");
    check_result(32'd9, "R8");
    check_result(32'd10, "R8");

    // R8 random results of varied length
    for (int k = 0; k < 20; k++)
      check_result($urandom >> ($urandom % 32), "R8");

    // R5 random keys
    for (int k = 0; k < 10; k++) begin
      logic [7:0] c;
      c = keys[$urandom % keys.len()];
      m = nw; press(c);
      check(nw - m == 1 && w_db[m] == c && w_rs[m] == 1'b1, "R5",
            "random key", w_db[m], c);
    end

    // R12: key and result in the same cycle
    m = nw;
    @(negedge clk); key_valid = 1'b1; key_char = "9";
    res_valid = 1'b1; res_value = 32'd4321;
    @(negedge clk); key_valid = 1'b0; res_valid = 1'b0;
    settle();
    check(nw - m == 1, "R12", "simultaneous write count", nw - m, 1);
    expect_w(m, 1'b1, "9", "R12");

    // R4: every strobe exactly E_HI wide
    ok = 1;
    for (int i = 0; i < nw; i++) if (w_hi[i] != E_HI) ok = 0;
    check(ok, "R4", "strobe widths", 0, E_HI);
    // R10: post-script gaps
    ok = 1;
    for (int i = 9; i < nw; i++) if (w_lo[i] < DGAP) ok = 0;
    check(ok, "R10", "post-script gaps", 0, DGAP);
    // R11
    check(rw_bad == 0, "R11", "rw high cycles", rw_bad, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule